// File: doc/BRIEF.md
# Single-Step Shift and Rotate Unit

This block is a purely combinational datapath element that takes an N-bit word and either hands it on untouched or moves every bit by exactly one place. It can move the bits towards the most significant end or towards the least significant end. Each move is either a plain shift or a rotation. In a plain shift, one of two external fill bits enters the end that was emptied. In a rotation, the bit pushed out of one end comes back in at the other.

A 3-bit operation code picks the behaviour. The codes whose top two bits are 01 are reserved, and they behave exactly like the pass-through codes so that the output is never undefined. Each output bit comes from its own four-input selector, which chooses between the bit itself, its lower neighbour and its upper neighbour. At the two ends, the missing neighbour is replaced by either a fill bit or the bit from the opposite end. The block is meant to sit between a register and an arithmetic stage, where the result is used in the same cycle.

Top module: `shrot_unit`

## Requirements
- R1: Operation codes 000 and 001 give data_o equal to data_i.
- R2: The reserved codes 010 and 011 also give data_o equal to data_i.
- R3: Code 100 moves the word one place towards the MSB. Bit 0 of data_o takes fill_lo_i, and bit k (k ≥ 1) takes data_i bit k-1.
- R4: Code 101 moves the word one place towards the MSB. Bit 0 of data_o takes data_i bit N-1, and both fill inputs are ignored.
- R5: Code 110 moves the word one place towards the LSB. Bit N-1 of data_o takes fill_hi_i, and bit k (k ≤ N-2) takes data_i bit k+1.
- R6: Code 111 moves the word one place towards the LSB. Bit N-1 of data_o takes data_i bit 0, and both fill inputs are ignored.
- R7: Under codes 000 to 011 the fill inputs have no effect on data_o.
- R8: The result depends only on the present inputs, with no clock and no state, so data_o is valid in the same cycle the inputs are applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | WIDTH | Word to be passed or moved |
| op_i | input | 3 | Operation code (see R1 to R6) |
| fill_lo_i | input | 1 | Bit that enters the LSB on a plain move towards the MSB |
| fill_hi_i | input | 1 | Bit that enters the MSB on a plain move towards the LSB |
| data_o | output | WIDTH | Result word |

## Verification
The block holds no state, so any internal fault shows up on data_o in the same evaluation that applies the offending inputs. A wrong decode of the operation code corrupts every bit position for that code. It shows on almost every data value, at the latest on the first non-trivial word. A faulty selector slice or a wrong end connection shows only in one bit position, and only for the codes and fill values that route through it. For that reason the sweep covers every data word, every code and all four fill combinations, so that each slice input is exercised with both polarities.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

   typedef enum logic [2:0] {
      OP_PASS_A = 3'b000,
      OP_PASS_B = 3'b001,
      OP_RSV_A  = 3'b010,
      OP_RSV_B  = 3'b011,
      OP_MSB_SH = 3'b100,
      OP_MSB_RO = 3'b101,
      OP_LSB_SH = 3'b110,
      OP_LSB_RO = 3'b111
   } shrot_op_e;

   typedef enum logic [1:0] {
      SEL_KEEP  = 2'd0,
      SEL_LOWER = 2'd1,
      SEL_UPPER = 2'd2,
      SEL_SPARE = 2'd3
   } shrot_sel_e;

   typedef struct packed {
      shrot_sel_e sel;
      logic       wrap;
   } shrot_ctl_t;

   localparam int SEL_INPUTS = 4;

endpackage

// File: rtl/shrot_sel4.sv
module shrot_sel4 #(
   parameter bit AND_OR = 1'b0
) (
   input  logic [1:0]                      s_i,
   input  logic [shrot_pkg::SEL_INPUTS-1:0] d_i,
   output logic                            y_o
);
   localparam int NIN = shrot_pkg::SEL_INPUTS;

   generate
      if (AND_OR) begin : g_andor
         logic [NIN-1:0] hot;
         always_comb begin
            hot = '0;
            hot[s_i] = 1'b1;
         end
         assign y_o = |(hot & d_i);
      end else begin : g_case
         always_comb begin
            case (s_i)
               2'd0:    y_o = d_i[0];
               2'd1:    y_o = d_i[1];
               2'd2:    y_o = d_i[2];
               default: y_o = d_i[3];
            endcase
         end
      end
   endgenerate
endmodule

// File: rtl/shrot_decode.sv
module shrot_decode
   import shrot_pkg::*;
(
   input  logic [2:0] op_i,
   output shrot_ctl_t ctl_o
);
   always_comb begin
      ctl_o.sel  = SEL_KEEP;
      ctl_o.wrap = 1'b0;
      if (op_i[2]) begin
         ctl_o.sel  = op_i[1] ? SEL_UPPER : SEL_LOWER;
         ctl_o.wrap = op_i[0];
      end
   end
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
   import shrot_pkg::*;
#(
   parameter int WIDTH      = 8,
   parameter bit AND_OR_SEL = 1'b0
) (
   input  logic [WIDTH-1:0] data_i,
   input  logic [2:0]       op_i,
   input  logic             fill_lo_i,
   input  logic             fill_hi_i,
   output logic [WIDTH-1:0] data_o
);
   localparam int MSB     = WIDTH - 1;
   localparam int EXT_MSB = WIDTH + 1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("shrot_unit: WIDTH must be at least 2");
      end
   endgenerate

   shrot_ctl_t ctl;

   shrot_decode u_dec (
      .op_i  (op_i),
      .ctl_o (ctl)
   );

   logic lo_entry;
   logic hi_entry;
   assign lo_entry = ctl.wrap ? data_i[MSB] : fill_lo_i;
   assign hi_entry = ctl.wrap ? data_i[0]   : fill_hi_i;

   // ext[k+1] is data bit k; ext[0] and ext[EXT_MSB] are the end entries
   logic [EXT_MSB:0] ext;
   assign ext = {hi_entry, data_i, lo_entry};

   generate
      for (genvar gi = 0; gi < WIDTH; gi++) begin : g_slice
         logic [SEL_INPUTS-1:0] cand;
         // order: keep, from lower, from upper, spare (= keep)
         assign cand = {ext[gi+1], ext[gi+2], ext[gi], ext[gi+1]};
         shrot_sel4 #(.AND_OR(AND_OR_SEL)) u_sel (
            .s_i (ctl.sel),
            .d_i (cand),
            .y_o (data_o[gi])
         );
      end
   endgenerate
endmodule

// File: rtl/shrot_unit_chk.sv
module shrot_unit_chk #(
   parameter int WIDTH = 8
) (
   input logic [WIDTH-1:0] data_i,
   input logic [2:0]       op_i,
   input logic             fill_lo_i,
   input logic             fill_hi_i,
   input logic [WIDTH-1:0] data_o
);
   always_comb begin
      if (!$isunknown({data_i, op_i, fill_lo_i, fill_hi_i})) begin
         if (op_i[2:1] == 2'b00) begin
            a_r1_pass: assert (data_o == data_i) else $error("R1 pass violated");
         end
         if (op_i[2:1] == 2'b01) begin
            a_r2_reserved_pass: assert (data_o == data_i) else $error("R2 reserved code altered data");
         end
         if (op_i == 3'b100) begin
            a_r3_lsb_fill: assert (data_o[0] == fill_lo_i) else $error("R3 fill bit wrong");
            a_r3_body: assert (data_o[WIDTH-1:1] == data_i[WIDTH-2:0]) else $error("R3 body wrong");
         end
         if (op_i == 3'b101) begin
            a_r4_wrap: assert (data_o[0] == data_i[WIDTH-1]) else $error("R4 wrap bit wrong");
            a_r4_ones: assert ($countones(data_o) == $countones(data_i)) else $error("R4 ones count changed");
         end
         if (op_i == 3'b110) begin
            a_r5_msb_fill: assert (data_o[WIDTH-1] == fill_hi_i) else $error("R5 fill bit wrong");
            a_r5_body: assert (data_o[WIDTH-2:0] == data_i[WIDTH-1:1]) else $error("R5 body wrong");
         end
         if (op_i == 3'b111) begin
            a_r6_wrap: assert (data_o[WIDTH-1] == data_i[0]) else $error("R6 wrap bit wrong");
            a_r6_ones: assert ($countones(data_o) == $countones(data_i)) else $error("R6 ones count changed");
         end
      end
   end
endmodule

bind shrot_unit shrot_unit_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/sim_shrot_unit.sv
module sim_shrot_unit;
   localparam int W = 8;
   localparam int WD_CYCLES = 20000;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] data_i = '0;
   logic [2:0]   op_i = '0;
   logic         fill_lo_i = 1'b0;
   logic         fill_hi_i = 1'b0;
   logic [W-1:0] data_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   shrot_unit #(.WIDTH(W)) u0 (
      .data_i    (data_i),
      .op_i      (op_i),
      .fill_lo_i (fill_lo_i),
      .fill_hi_i (fill_hi_i),
      .data_o    (data_o)
   );

   function automatic logic [W-1:0] model(logic [W-1:0] d, logic [2:0] op, logic lo, logic hi);
      logic [W-1:0] r;
      case (op)
         3'b100:  r = (d << 1) | W'(lo);
         3'b101:  r = (d << 1) | (d >> (W - 1));
         3'b110:  r = (d >> 1) | (W'(hi) << (W - 1));
         3'b111:  r = (d >> 1) | (d << (W - 1));
         default: r = d;
      endcase
      return r;
   endfunction

   function automatic string tag(logic [2:0] op);
      case (op)
         3'b000, 3'b001: return "R1 R7 R8";
         3'b010, 3'b011: return "R2 R7 R8";
         3'b100:         return "R3 R8";
         3'b101:         return "R4 R8";
         3'b110:         return "R5 R8";
         default:        return "R6 R8";
      endcase
   endfunction

   task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s op=%b d=%h lo=%b hi=%b actual=%h expected=%h",
                  req, op_i, data_i, fill_lo_i, fill_hi_i, act, exp);
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 reset", data_o, '0);
      rst = 1'b0;
      for (int op = 0; op < 8; op++) begin
         for (int f = 0; f < 4; f++) begin
            for (int d = 0; d < (1 << W); d++) begin
               @(posedge clk);
               #1;
               op_i      = 3'(op);
               fill_lo_i = f[0];
               fill_hi_i = f[1];
               data_i    = W'(d);
               @(negedge clk);
               check(tag(op_i), data_o, model(data_i, op_i, fill_lo_i, fill_hi_i));
            end
         end
      end
      // R4/R6 end cases: single bit at each end, fills set against the expected value
      @(posedge clk); #1;
      op_i = 3'b101; data_i = W'(1) << (W - 1); fill_lo_i = 1'b0; fill_hi_i = 1'b0;
      @(negedge clk);
      check("R4 wrap to LSB", data_o, W'(1));
      @(posedge clk); #1;
      op_i = 3'b111; data_i = W'(1); fill_lo_i = 1'b0; fill_hi_i = 1'b0;
      @(negedge clk);
      check("R6 wrap to MSB", data_o, W'(1) << (W - 1));
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule